// File: doc/BRIEF.md
# Taken-Branch Sequencer for an Eight-Stage In-Order Pipeline

This block tracks which instructions are live in an eight-stage in-order pipeline. The stages are IF, IS, RF, EX, DF, DS, TC and WB. Instruction fetch takes two stages (IF, IS). Data access takes three (DF, DS, TC), and TC is the tag check. Each stage holds a valid bit, an instruction tag and a branch marker. Every clock, each of them moves one stage down, and the fetch port fills IF.

Branches are resolved in EX. The instruction just behind a branch is its delay slot, and it always completes. On a taken branch the block raises a one-cycle redirect strobe and a squash strobe. The two younger sequential fetches, sitting in IF and IS, then move on as invalid entries, so they can never write registers or memory. The branch target, fetched on the edge that ends the redirect cycle, follows them. EX therefore sees: branch, delay slot, two bubbles, target.

A not-taken branch disturbs nothing. A branch that sits in another branch's delay slot is an illegal sequence, and an error output flags it.

Top module: `branch_seq_top`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, every bit of stageValid is 0, and squash, redirectPc and illegalSeq are 0.
- R2: Stage index 0..7 stands for IF, IS, RF, EX, DF, DS, TC, WB. stageValid bit i is stage i, and stageTag bits [i*TAG_W +: TAG_W] are its tag. On each rising edge, stage 0 takes {fetchValid, fetchTag, fetchIsBranch}, and stage i takes the contents of stage i-1, except as R4 states.
- R3: redirectPc is 1 in exactly those cycles where EX holds a valid branch and exTaken is 1. For a legal sequence it stays high for one cycle per taken branch.
- R4: squash is 1 in the same cycles as redirectPc. On the edge that ends such a cycle, IS and RF become invalid, whatever IF and IS held.
- R5: The delay slot (the RF entry during a redirect cycle) reaches EX with its valid bit and tag unchanged.
- R6: A fetch presented during the redirect cycle enters IF valid. Over the next four cycles EX shows, in order: delay slot, bubble, bubble, target.
- R7: For a not-taken branch (exTaken 0 while the branch is in EX), no stage is invalidated, and EX shows four consecutive valid sequential instructions.
- R8: exTaken has no effect when EX does not hold a valid branch. redirectPc and squash stay 0, and no stage is invalidated.
- R9: illegalSeq is 1 exactly when EX holds a valid branch and RF holds a valid branch.
- R10: A tag travels with its instruction. The tag of every valid stage equals the tag fetched with that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A real instruction is being fetched into IF |
| fetchTag | input | TAG_W | Tag of the instruction being fetched |
| fetchIsBranch | input | 1 | Decode flag: the fetched instruction is a branch |
| exTaken | input | 1 | Resolution for the branch currently in EX (1 = taken) |
| stageValid | output | 8 | Per-stage valid bits, bit 0 = IF, bit 7 = WB |
| stageTag | output | 8*TAG_W | Per-stage tags, packed by stage index |
| squash | output | 1 | Front-end kill strobe: IF and IS contents become bubbles |
| redirectPc | output | 1 | Strobe telling fetch to load the branch target |
| illegalSeq | output | 1 | A branch occupies another branch's delay slot |

## Verification
A redirect and the illegal-sequence flag can fall in the same cycle. This happens when a taken branch in EX has a second branch in its delay slot. The directed case provokes it by fetching two branches back to back and resolving the first one taken. The random stream then produces it again with the taken bit drawn at random. In that cycle the bench expects redirectPc, squash and illegalSeq all high, with the slot branch still surviving into EX. It then expects that second branch to be able to redirect again on its own.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;
  localparam int NUM_STAGES = 8;
  localparam int ST_IF = 0;
  localparam int ST_IS = 1;
  localparam int ST_RF = 2;
  localparam int ST_EX = 3;
  localparam int ST_WB = 7;

  // strobes from control to stage registers
  typedef struct packed {
    logic killFront;
    logic redirect;
    logic illegal;
  } seqStrobes_t;
endpackage

// File: rtl/branch_seq_stages.sv
module branch_seq_stages
  import branch_seq_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int N_ST  = NUM_STAGES,
  parameter int EX_IX = ST_EX
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inValid,
  input  logic [TAG_W-1:0]           inTag,
  input  logic                       inBranch,
  input  seqStrobes_t                strobes,
  output logic [N_ST-1:0]            vld,
  output logic [N_ST-1:0][TAG_W-1:0] tag,
  output logic [N_ST-1:0]            br
);
  // stages fed by an entry younger than the delay slot
  localparam int LAST_KILLED = EX_IX - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= 1'b0;
      br[0]  <= 1'b0;
      tag[0] <= '0;
    end else begin
      vld[0] <= inValid;
      br[0]  <= inBranch;
      tag[0] <= inTag;
    end
  end

  for (genvar i = 1; i < N_ST; i++) begin : g_stage
    logic killHere;
    if (i <= LAST_KILLED) begin : g_kill
      assign killHere = strobes.killFront;
    end else begin : g_keep
      assign killHere = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        br[i]  <= 1'b0;
        tag[i] <= '0;
      end else begin
        vld[i] <= vld[i-1] & ~killHere;
        br[i]  <= br[i-1];
        tag[i] <= tag[i-1];
      end
    end
  end
endmodule

// File: rtl/branch_seq_ctrl.sv
module branch_seq_ctrl
  import branch_seq_pkg::*;
(
  input  logic        exValid,
  input  logic        exBranch,
  input  logic        slotValid,
  input  logic        slotBranch,
  input  logic        taken,
  output seqStrobes_t strobes
);
  logic exIsBranch;
  logic takenNow;

  assign exIsBranch = exValid & exBranch;
  assign takenNow   = exIsBranch & taken;

  always_comb begin
    strobes           = '0;
    strobes.redirect  = takenNow;
    strobes.killFront = takenNow;
    strobes.illegal   = exIsBranch & slotValid & slotBranch;
  end
endmodule

// File: rtl/branch_seq_top.sv
module branch_seq_top
  import branch_seq_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fetchValid,
  input  logic [TAG_W-1:0]              fetchTag,
  input  logic                          fetchIsBranch,
  input  logic                          exTaken,
  output logic [NUM_STAGES-1:0]         stageValid,
  output logic [NUM_STAGES*TAG_W-1:0]   stageTag,
  output logic                          squash,
  output logic                          redirectPc,
  output logic                          illegalSeq
);
  logic [NUM_STAGES-1:0]            vld;
  logic [NUM_STAGES-1:0]            br;
  logic [NUM_STAGES-1:0][TAG_W-1:0] tag;
  seqStrobes_t                      strobes;

  branch_seq_ctrl ctrl_i (
    .exValid   (vld[ST_EX]),
    .exBranch  (br[ST_EX]),
    .slotValid (vld[ST_RF]),
    .slotBranch(br[ST_RF]),
    .taken     (exTaken),
    .strobes   (strobes)
  );

  branch_seq_stages #(
    .TAG_W(TAG_W),
    .N_ST (NUM_STAGES),
    .EX_IX(ST_EX)
  ) stages_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (fetchValid),
    .inTag   (fetchTag),
    .inBranch(fetchIsBranch),
    .strobes (strobes),
    .vld     (vld),
    .tag     (tag),
    .br      (br)
  );

  assign stageValid = vld;
  assign stageTag   = tag;
  assign squash     = strobes.killFront;
  assign redirectPc = strobes.redirect;
  assign illegalSeq = strobes.illegal;
endmodule

// File: rtl/branch_seq_checker.sv
module branch_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] stageValid,
  input logic       squash,
  input logic       redirectPc,
  input logic       illegalSeq
);
  // R3: one redirect per legal taken branch
  a_r3_redirect_single: assert property (@(posedge clk) disable iff (!rst_n)
    (redirectPc && !illegalSeq) |=> !redirectPc);

  // R4: the two front stages are bubbles after a squash
  a_r4_front_killed: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (!stageValid[1] && !stageValid[2]));

  // R5: the delay slot survives the redirect
  a_r5_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    redirectPc |=> (stageValid[3] == $past(stageValid[2])));

  // R2: back end never loses an entry
  a_r2_back_shift: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stageValid[7:4] == $past(stageValid[6:3])));

  // R8: without a redirect the front end shifts untouched
  a_r8_no_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !squash |=> (stageValid[2:1] == $past(stageValid[1:0])));

  // R9: an illegal flag needs live entries in EX and RF
  a_r9_illegal_pair: assert property (@(posedge clk) disable iff (!rst_n)
    illegalSeq |-> (stageValid[3] && stageValid[2]));
endmodule

bind branch_seq_top branch_seq_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stageValid(stageValid),
  .squash    (squash),
  .redirectPc(redirectPc),
  .illegalSeq(illegalSeq)
);

// File: tb/branch_seq_top_tb_top.sv
module branch_seq_top_tb_top;
  localparam int TW = 8;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetchValid = 1'b0;
  logic [TW-1:0] fetchTag = '0;
  logic fetchIsBranch = 1'b0;
  logic exTaken = 1'b0;
  logic [NS-1:0] stageValid;
  logic [NS*TW-1:0] stageTag;
  logic squash, redirectPc, illegalSeq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [NS-1:0] mv = '0;
  logic [NS-1:0] mb = '0;
  logic [TW-1:0] mt [NS];
  logic lastRedir, lastIll, lastSquash;

  always #2 clk = ~clk;

  branch_seq_top #(.TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchTag(fetchTag),
    .fetchIsBranch(fetchIsBranch), .exTaken(exTaken), .stageValid(stageValid),
    .stageTag(stageTag), .squash(squash), .redirectPc(redirectPc),
    .illegalSeq(illegalSeq)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expRedirect(input logic tk);
    return mv[3] && mb[3] && tk;
  endfunction

  function automatic logic expIllegal();
    return mv[3] && mb[3] && mv[2] && mb[2];
  endfunction

  // one cycle: drive, check against model, advance model
  task automatic step(input logic fv, input logic [TW-1:0] ft, input logic fb, input logic tk);
    logic er, ei;
    logic [NS-1:0] nv, nb;
    logic [TW-1:0] nt [NS];
    @(negedge clk);
    fetchValid = fv; fetchTag = ft; fetchIsBranch = fb; exTaken = tk;
    #1;
    er = expRedirect(tk);
    ei = expIllegal();
    chk(stageValid == mv, "R2 R4 stageValid", int'(stageValid), int'(mv));
    for (int i = 0; i < NS; i++)
      if (mv[i]) chk(stageTag[i*TW +: TW] == mt[i], "R10 tag", int'(stageTag[i*TW +: TW]), int'(mt[i]));
    chk(redirectPc == er, "R3 R8 redirectPc", int'(redirectPc), int'(er));
    chk(squash == er, "R4 R8 squash", int'(squash), int'(er));
    chk(illegalSeq == ei, "R9 illegalSeq", int'(illegalSeq), int'(ei));
    lastRedir = redirectPc; lastIll = illegalSeq; lastSquash = squash;
    nv[0] = fv; nb[0] = fb; nt[0] = ft;
    for (int i = 1; i < NS; i++) begin
      nv[i] = mv[i-1] && !(er && (i == 1 || i == 2));
      nb[i] = mb[i-1];
      nt[i] = mt[i-1];
    end
    @(posedge clk);
    mv = nv; mb = nb;
    for (int i = 0; i < NS; i++) mt[i] = nt[i];
    cycles++;
  endtask

  task automatic exIs(input logic v, input logic [TW-1:0] t, input string req);
    #1;
    chk(stageValid[3] == v, req, int'(stageValid[3]), int'(v));
    if (v) chk(stageTag[3*TW +: TW] == t, req, int'(stageTag[3*TW +: TW]), int'(t));
  endtask

  task automatic flush();
    for (int i = 0; i < NS; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic lastFb;
    for (int i = 0; i < NS; i++) mt[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(stageValid == '0, "R1 valid in reset", int'(stageValid), 0);
    chk({squash, redirectPc, illegalSeq} == 3'b000, "R1 strobes in reset",
        int'({squash, redirectPc, illegalSeq}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(stageValid == '0, "R1 valid after reset", int'(stageValid), 0);

    // taken branch: slot, two bubbles, target
    step(1, 8'h10, 1, 0);
    step(1, 8'h11, 0, 0);
    step(1, 8'h12, 0, 0);
    step(1, 8'h13, 0, 1);
    step(1, 8'h20, 0, 1);
    chk(lastRedir == 1'b1, "R3 redirect on taken", int'(lastRedir), 1);
    chk(lastSquash == 1'b1, "R4 squash on taken", int'(lastSquash), 1);
    exIs(1'b1, 8'h11, "R5 slot in EX");
    step(1, 8'h21, 0, 1);
    chk(lastRedir == 1'b0, "R3 R8 single redirect", int'(lastRedir), 0);
    exIs(1'b0, '0, "R6 bubble one");
    step(1, 8'h22, 0, 0);
    exIs(1'b0, '0, "R6 bubble two");
    step(1, 8'h23, 0, 0);
    exIs(1'b1, 8'h20, "R6 target in EX");
    flush();

    // not taken: no bubbles
    step(1, 8'h40, 1, 0);
    step(1, 8'h41, 0, 0);
    step(1, 8'h42, 0, 0);
    step(1, 8'h43, 0, 0);
    step(1, 8'h44, 0, 0);
    chk(lastRedir == 1'b0, "R7 no redirect", int'(lastRedir), 0);
    exIs(1'b1, 8'h41, "R7 seq 1");
    step(1, 8'h45, 0, 0);
    exIs(1'b1, 8'h42, "R7 seq 2");
    step(1, 8'h46, 0, 0);
    exIs(1'b1, 8'h43, "R7 seq 3");
    step(1, 8'h47, 0, 0);
    exIs(1'b1, 8'h44, "R7 seq 4");
    flush();

    // branch in delay slot, first one taken: redirect and illegal together
    step(1, 8'h60, 1, 0);
    step(1, 8'h61, 1, 0);
    step(1, 8'h62, 0, 0);
    step(1, 8'h63, 0, 0);
    step(1, 8'h70, 0, 1);
    chk(lastIll == 1'b1, "R9 illegal flagged", int'(lastIll), 1);
    chk(lastRedir == 1'b1, "R9 R3 redirect with illegal", int'(lastRedir), 1);
    exIs(1'b1, 8'h61, "R9 R5 slot branch in EX");
    step(1, 8'h71, 0, 1);
    chk(lastRedir == 1'b1, "R9 R3 slot branch redirects", int'(lastRedir), 1);
    flush();

    // exTaken with no branch in EX
    step(1, 8'h80, 0, 1);
    step(1, 8'h81, 0, 1);
    step(1, 8'h82, 0, 1);
    step(1, 8'h83, 0, 1);
    chk(lastRedir == 1'b0, "R8 taken ignored", int'(lastRedir), 0);
    exIs(1'b1, 8'h80, "R8 no kill");

    // constrained random mix
    lastFb = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      logic fv, fb, tk;
      fv = ($urandom % 5) != 0;
      fb = fv && (($urandom % 4) == 0) && (!lastFb || (($urandom % 8) == 0));
      tk = $urandom % 2;
      step(fv, 8'($urandom), fb, tk);
      lastFb = fb;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule